// File: doc/BRIEF.md
# Packing Acquisition FIFO with Overflow Lock

This block sits between an acquisition engine that produces 16-bit sample words and a consumer that drains 32-bit words. Each two accepted 16-bit writes are joined into one 32-bit entry. The occupancy count is reported in 16-bit words, including a half-built pair.

When a write arrives while the buffer is full, a sticky overflow flag is raised. From then on every write is refused until the acquisition reset clears the flag. A stream that has lost data therefore never resumes in the middle of a block. Reads continue while the flag is set, so the consumer can still drain what was stored before the loss. One clock drives the whole block. The reset clears the pointers, the pending half-word and the overflow flag.

Top module: `acq_pack_fifo`

## Requirements
- R1: The first accepted 16-bit word of a pair lands in bits [15:0] of the 32-bit entry, and the second lands in bits [31:16].
- R2: A single pending 16-bit word is not readable: `empty` stays 1 until one complete 32-bit entry exists.
- R3: `{count_hi, count_lo}` gives the number of stored 16-bit words. This is twice the number of complete entries, plus one if a half-word is pending.
- R4: `full` is 1 exactly when 4096 words are stored, which is 2048 entries.
- R5: A write request while `full` is 1 sets `overflow` on the next clock and stores nothing.
- R6: Once `overflow` is 1, it stays 1 and every write request is ignored until reset. The count never grows in that state.
- R7: Reads continue to return stored entries while `overflow` is 1.
- R8: `rd_data` shows the oldest entry in the clock after `rd_en` is sampled while `empty` is 0. A read request while `empty` is 1 has no effect.
- R9: An active-low reset returns the block to its initial state: `empty` 1, `full` 0, count 0, `overflow` 0, no pending half-word. Writes are accepted again after reset.
- R10: Entries leave the FIFO in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Acquisition reset, active low |
| wr_en | input | 1 | Write request for one 16-bit word |
| wr_data | input | 16 | Word to store |
| full | output | 1 | Buffer holds its full capacity in words |
| rd_en | input | 1 | Read request for one 32-bit entry |
| rd_data | output | 32 | Entry read, valid the clock after `rd_en` |
| empty | output | 1 | No complete 32-bit entry is stored |
| count_lo | output | 16 | Stored word count, bits [15:0] |
| count_hi | output | 16 | Stored word count, bits [31:16] |
| overflow | output | 1 | Sticky overflow indicator |

## Verification
The assertions assume that `wr_en` and `rd_en` are known (never X) whenever reset is inactive. They also assume that reset is held for at least one clock before it is released. The bench changes every input only on the falling clock edge, and it holds reset across two rising edges before each release. Writes while full and reads while empty are legal inputs. The bench drives both deliberately so that the lock and ignore paths run under the same assumptions.

// File: rtl/acq_fifo_pkg.sv
package acq_fifo_pkg;

   // Width of a counter that must hold values 0..max_val inclusive.
   function automatic int cnt_width(input int max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

   // Width of an index into n items (at least one bit).
   function automatic int idx_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/acq_half_packer.sv
module acq_half_packer
   import acq_fifo_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int RATIO = 2,
   localparam int OUT_W  = IN_W * RATIO,
   localparam int LANE_W = idx_width(RATIO)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [IN_W-1:0]   din,
   output logic              ent_valid,
   output logic [OUT_W-1:0]  ent_data,
   output logic [LANE_W-1:0] lane_q
);

   generate
      if (RATIO < 1) begin : g_bad_ratio
         $error("acq_half_packer: RATIO must be at least 1");
      end

      if (RATIO == 1) begin : g_direct
         assign lane_q    = '0;
         assign ent_valid = push;
         assign ent_data  = din;
      end else begin : g_pack
         logic [IN_W-1:0] hold_q [RATIO-1];
         logic            last_lane;

         assign last_lane = (lane_q == LANE_W'(RATIO - 1));
         assign ent_valid = push && last_lane;

         // The earlier lanes are held; the final lane comes straight from the input.
         for (genvar g = 0; g < RATIO - 1; g++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  hold_q[g] <= '0;
               end else if (push && (lane_q == LANE_W'(g))) begin
                  hold_q[g] <= din;
               end
            end
            assign ent_data[g*IN_W +: IN_W] = hold_q[g];
         end
         assign ent_data[(RATIO-1)*IN_W +: IN_W] = din;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else if (push) begin
               lane_q <= last_lane ? '0 : lane_q + 1'b1;
            end
         end

         // R1: once an entry is emitted, the next word starts a new pair in the low lane
         a_r1_lane_restart: assert property (@(posedge clk) disable iff (!rst_n)
            ent_valid |=> (lane_q == '0));

         // R1: a push that does not complete an entry moves to the next lane
         a_r1_lane_advance: assert property (@(posedge clk) disable iff (!rst_n)
            (push && !ent_valid) |=> (lane_q == $past(lane_q) + 1'b1));
      end
   endgenerate

endmodule

// File: rtl/acq_fifo_store.sv
module acq_fifo_store
   import acq_fifo_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 2048,
   localparam int AW    = idx_width(DEPTH),
   localparam int ENT_W = cnt_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [DW-1:0]    wdata,
   input  logic             rd_req,
   output logic [DW-1:0]    rd_data,
   output logic [ENT_W-1:0] entries,
   output logic             empty
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("acq_fifo_store: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic          rd_fire;

   assign empty   = (entries == '0);
   assign rd_fire = rd_req && !empty;

   always_ff @(posedge clk) begin
      if (wr) begin
         mem[wptr_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_fire) begin
         rd_data <= mem[rptr_q];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         entries <= '0;
      end else begin
         if (wr) begin
            wptr_q <= wptr_q + 1'b1;
         end
         if (rd_fire) begin
            rptr_q <= rptr_q + 1'b1;
         end
         case ({wr, rd_fire})
            2'b10:   entries <= entries + 1'b1;
            2'b01:   entries <= entries - 1'b1;
            default: entries <= entries;
         endcase
      end
   end

   // R4: the writer never pushes into a store that holds DEPTH entries
   a_r4_no_write_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (entries != ENT_W'(DEPTH)));

   // R8: a read request while empty leaves the read pointer and data untouched
   a_r8_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty) |=> ($stable(rptr_q) && $stable(rd_data)));

   // R10: write and read pointers stay consistent with the occupancy
   a_r10_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (entries != ENT_W'(DEPTH)) |-> (AW'(wptr_q - rptr_q) == AW'(entries)));

endmodule

// File: rtl/acq_ovf_guard.sv
module acq_ovf_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_req,
   input  logic full,
   output logic accept,
   output logic ovf_q
);

   assign accept = wr_req && !full && !ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (wr_req && full) begin
         ovf_q <= 1'b1;
      end
   end

   // R5: a write request that meets a full buffer raises the flag
   a_r5_ovf_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full) |=> ovf_q);

   // R6: the flag holds until reset
   a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R6: nothing is accepted while the flag is set
   a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> !accept);

endmodule

// File: rtl/acq_pack_fifo.sv
module acq_pack_fifo
   import acq_fifo_pkg::*;
#(
   parameter int IN_W        = 16,
   parameter int OUT_W       = 32,
   parameter int DEPTH_WORDS = 4096,
   parameter int CNT_HALF_W  = 16,
   localparam int RATIO     = OUT_W / IN_W,
   localparam int DEPTH_ENT = DEPTH_WORDS / RATIO,
   localparam int ENT_W     = cnt_width(DEPTH_ENT),
   localparam int LANE_W    = idx_width(RATIO),
   localparam int WCNT_W    = cnt_width(DEPTH_WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IN_W-1:0]       wr_data,
   output logic                  full,
   input  logic                  rd_en,
   output logic [OUT_W-1:0]      rd_data,
   output logic                  empty,
   output logic [CNT_HALF_W-1:0] count_lo,
   output logic [CNT_HALF_W-1:0] count_hi,
   output logic                  overflow
);

   generate
      if (OUT_W % IN_W != 0) begin : g_bad_width
         $error("acq_pack_fifo: OUT_W must be a multiple of IN_W");
      end
      if (DEPTH_WORDS % RATIO != 0) begin : g_bad_depth
         $error("acq_pack_fifo: DEPTH_WORDS must be a multiple of OUT_W/IN_W");
      end
      if (WCNT_W > 2 * CNT_HALF_W) begin : g_bad_cnt
         $error("acq_pack_fifo: word count does not fit in two count halves");
      end
   endgenerate

   logic              accept;
   logic              ent_valid;
   logic [OUT_W-1:0]  ent_data;
   logic [LANE_W-1:0] lane_w;
   logic [ENT_W-1:0]  ent_w;
   logic [WCNT_W-1:0] words_w;
   logic [2*CNT_HALF_W-1:0] count_full;

   acq_ovf_guard u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_req (wr_en),
      .full   (full),
      .accept (accept),
      .ovf_q  (overflow)
   );

   acq_half_packer #(
      .IN_W  (IN_W),
      .RATIO (RATIO)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .din       (wr_data),
      .ent_valid (ent_valid),
      .ent_data  (ent_data),
      .lane_q    (lane_w)
   );

   acq_fifo_store #(
      .DW    (OUT_W),
      .DEPTH (DEPTH_ENT)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ent_valid),
      .wdata   (ent_data),
      .rd_req  (rd_en),
      .rd_data (rd_data),
      .entries (ent_w),
      .empty   (empty)
   );

   // Occupancy in input words: complete entries plus the pending lanes.
   assign words_w    = WCNT_W'(ent_w) * WCNT_W'(RATIO) + WCNT_W'(lane_w);
   assign full       = (words_w == WCNT_W'(DEPTH_WORDS));
   assign count_full = (2*CNT_HALF_W)'(words_w);
   assign count_lo   = count_full[CNT_HALF_W-1:0];
   assign count_hi   = count_full[2*CNT_HALF_W-1:CNT_HALF_W];

   // R4: occupancy never exceeds capacity
   a_r4_within_capacity: assert property (@(posedge clk) disable iff (!rst_n)
      words_w <= WCNT_W'(DEPTH_WORDS));

   // R2: fewer words than one entry means nothing is readable
   a_r2_partial_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (words_w < WCNT_W'(RATIO)) |-> empty);

   // R6: the count cannot grow while the lock is set
   a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> (words_w <= $past(words_w)));

   // R3: an accepted word without a read adds exactly one to the count
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rd_en) |=> (words_w == $past(words_w) + 1'b1));

endmodule

// File: tb/acq_pack_fifo_tb.sv
module acq_pack_fifo_tb_top;

   localparam int CLK_HALF = 10;   // 50 MHz
   localparam int NWORDS   = 4096;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en;
   logic [15:0] wr_data;
   logic        full, empty, overflow;
   logic [31:0] rd_data;
   logic [15:0] count_lo, count_hi;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #CLK_HALF clk = ~clk;

   acq_pack_fifo dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .full     (full),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .empty    (empty),
      .count_lo (count_lo),
      .count_hi (count_hi),
      .overflow (overflow)
   );

   typedef struct packed {
      logic        we;
      logic [15:0] wd;
      logic        re;
      logic        exp_empty;
      logic [31:0] exp_cnt;
      logic        chk_rd;
      logic [31:0] exp_rd;
   } vec_t;

   // One step per row, applied from the reset state.
   localparam vec_t VECS [9] = '{
      '{1'b1, 16'h1111, 1'b0, 1'b1, 32'd1, 1'b0, 32'h0},          // R2 half pair hidden
      '{1'b0, 16'h0000, 1'b1, 1'b1, 32'd1, 1'b0, 32'h0},          // R8 read while empty
      '{1'b1, 16'h2222, 1'b0, 1'b0, 32'd2, 1'b0, 32'h0},
      '{1'b1, 16'h3333, 1'b0, 1'b0, 32'd3, 1'b0, 32'h0},
      '{1'b1, 16'h4444, 1'b0, 1'b0, 32'd4, 1'b0, 32'h0},
      '{1'b0, 16'h0000, 1'b1, 1'b0, 32'd2, 1'b1, 32'h2222_1111},  // R1 lane order
      '{1'b1, 16'h5555, 1'b1, 1'b1, 32'd1, 1'b1, 32'h4444_3333},  // R10 read+write
      '{1'b1, 16'h6666, 1'b0, 1'b0, 32'd2, 1'b0, 32'h0},
      '{1'b0, 16'h0000, 1'b1, 1'b1, 32'd0, 1'b1, 32'h6666_5555}
   };

   function automatic logic [15:0] pattern(input int i);
      return 16'(i) ^ 16'hA5C3;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // Drive on the falling edge, let one rising edge pass, sample 2 ns later.
   task automatic step(input logic we, input logic [15:0] wd, input logic re);
      @(negedge clk);
      wr_en   = we;
      wr_data = wd;
      rd_en   = re;
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      rd_en = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
   endtask

   function automatic logic [31:0] cnt();
      return {count_hi, count_lo};
   endfunction

   initial begin
      rst_n   = 1'b1;
      wr_en   = 1'b0;
      rd_en   = 1'b0;
      wr_data = '0;
      do_reset();

      // R9 reset state
      chk(empty == 1'b1, "R9 empty after reset", 32'(empty), 32'd1);
      chk(full == 1'b0, "R9 full after reset", 32'(full), 32'd0);
      chk(cnt() == 32'd0, "R9 count after reset", cnt(), 32'd0);
      chk(overflow == 1'b0, "R9 overflow after reset", 32'(overflow), 32'd0);

      // Vector table: R1 R2 R3 R8 R10
      foreach (VECS[i]) begin
         step(VECS[i].we, VECS[i].wd, VECS[i].re);
         chk(empty == VECS[i].exp_empty, "R2 empty in table", 32'(empty),
             32'(VECS[i].exp_empty));
         chk(cnt() == VECS[i].exp_cnt, "R3 count in table", cnt(), VECS[i].exp_cnt);
         if (VECS[i].chk_rd) begin
            chk(rd_data == VECS[i].exp_rd, "R1 R10 data in table", rd_data,
                VECS[i].exp_rd);
         end
      end

      // Fill to capacity: R4
      for (int i = 0; i < NWORDS; i++) begin
         step(1'b1, pattern(i), 1'b0);
         if (i == NWORDS - 2) begin
            chk(full == 1'b0, "R4 not full one word short", 32'(full), 32'd0);
         end
      end
      chk(full == 1'b1, "R4 full at capacity", 32'(full), 32'd1);
      chk(count_lo == 16'h1000 && count_hi == 16'h0, "R3 count split at capacity",
          cnt(), 32'h0000_1000);
      chk(overflow == 1'b0, "R5 no overflow before excess write", 32'(overflow), 32'd0);

      // Excess write: R5
      step(1'b1, 16'hDEAD, 1'b0);
      chk(overflow == 1'b1, "R5 overflow raised", 32'(overflow), 32'd1);
      chk(cnt() == 32'd4096, "R5 excess word not stored", cnt(), 32'd4096);

      // Read one entry while locked: R7
      step(1'b0, 16'h0, 1'b1);
      chk(rd_data == {pattern(1), pattern(0)}, "R7 read while locked", rd_data,
          {pattern(1), pattern(0)});
      chk(cnt() == 32'd4094, "R7 count after read", cnt(), 32'd4094);
      chk(full == 1'b0, "R4 full clears after read", 32'(full), 32'd0);

      // Write with room available is still refused: R6
      step(1'b1, 16'hBEEF, 1'b0);
      chk(cnt() == 32'd4094, "R6 write refused while locked", cnt(), 32'd4094);
      chk(overflow == 1'b1, "R6 overflow sticky", 32'(overflow), 32'd1);

      // Drain the rest in order: R10
      begin
         int bad = 0;
         logic [31:0] first_bad_act = '0, first_bad_exp = '0;
         for (int k = 1; k < NWORDS / 2; k++) begin
            step(1'b0, 16'h0, 1'b1);
            if (rd_data != {pattern(2*k+1), pattern(2*k)}) begin
               if (bad == 0) begin
                  first_bad_act = rd_data;
                  first_bad_exp = {pattern(2*k+1), pattern(2*k)};
               end
               bad++;
            end
         end
         chk(bad == 0, "R10 drain order", first_bad_act, first_bad_exp);
      end
      chk(empty == 1'b1, "R8 empty after drain", 32'(empty), 32'd1);
      chk(cnt() == 32'd0, "R3 count after drain", cnt(), 32'd0);
      chk(overflow == 1'b1, "R6 overflow held after drain", 32'(overflow), 32'd1);

      // Reset releases the lock: R9
      do_reset();
      chk(overflow == 1'b0, "R9 overflow cleared", 32'(overflow), 32'd0);
      step(1'b1, 16'hAAAA, 1'b0);
      step(1'b1, 16'hBBBB, 1'b0);
      chk(cnt() == 32'd2, "R9 writes accepted after reset", cnt(), 32'd2);
      step(1'b0, 16'h0, 1'b1);
      chk(rd_data == 32'hBBBB_AAAA, "R1 pair after reset", rd_data, 32'hBBBB_AAAA);

      // Reset with a pending half-word discards it: R9
      step(1'b1, 16'h7777, 1'b0);
      do_reset();
      step(1'b1, 16'h1234, 1'b0);
      step(1'b1, 16'h5678, 1'b0);
      step(1'b0, 16'h0, 1'b1);
      chk(rd_data == 32'h5678_1234, "R9 pending half cleared", rd_data, 32'h5678_1234);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(64'd200000 * 2 * CLK_HALF);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule